// File: doc/BRIEF.md
# Parallel Multi-Chain Scan Driver

This block turns register writes from a 32-bit host bus into boundary-scan activity on many scan chains at the same time. The chains are grouped by mezzanine card, four cards of eight chains each by default. Every chain has its own mode-select (TMS) and data-in (TDI) line. All chains share one test clock (TCK). One host data word therefore sets one bit on every chain, and one command advances all of them by a single TCK period. The block is used to load configuration into a large set of pattern-matching chips without walking them one after another.

Software writes the data bits and the mode bits into two registers, then writes the command register. The sequencer moves from `ST_IDLE` to `ST_SETUP` (go transition). In `ST_SETUP` the new TDI and TMS values stand for one system clock while TCK is low. The sequencer then enters `ST_HIGH` (rise transition), where TCK stays high for a programmable number of system clocks. On the edge that raises TCK, the data-out (TDO) bits of all chains are captured. When the count expires the sequencer returns to `ST_IDLE` (fall transition) and TCK is low again. While the sequencer is not idle the block reports busy and ignores every host write. A per-chain enable mask parks disabled chains with TMS high and TDI low.

Top module: `mcj_driver`

## Requirements
- R1: A write to address 0 while idle loads the TDI register, which reads back at address 0. Data bit 8*m+k drives output `tdi` bit 8*m+k, which is chain k of mezzanine m. Byte 3 therefore serves mezzanine 3, and bit 31 reaches its chain 7.
- R2: A write to address 1 while idle loads the TMS register, which reads back at address 1. It uses the same bit-to-chain mapping as R1 on output `tms`.
- R3: The enable mask at address 2 resets to all ones and reads back. A chain whose mask bit is 0 drives TMS 1 and TDI 0, whatever the TDI and TMS registers hold.
- R4: The TCK high time at address 3 (8 bits) resets to 1 and reads back. TCK stays high for that many system clocks, and a value of 0 acts as 1.
- R5: A write of any data to address 4 while idle starts one TCK period. The cycle after that write is a single setup cycle with busy 1 and TCK 0. TCK is then high for the high time of R4, after which TCK is 0 and busy is 0.
- R6: On the edge that raises TCK, the `tdo` inputs of all chains are captured into a register read at address 6. The register keeps that value until the next rising TCK, even if `tdo` changes.
- R7: Address 5 reads busy in bit 0, with all other bits 0. Busy is 1 from the cycle after a command write until TCK has returned low.
- R8: Every host write made while busy is 1 is ignored, including a command write. No register changes and no further TCK period follows.
- R9: After reset, TCK is 0, busy is 0, the TDI, TMS and capture registers are 0, the mask is all ones and the high time is 1.
- R10: The `tdi` and `tms` outputs do not change while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| host_addr | input | 3 | Register address for both write and read |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| tck | output | 1 | Shared test clock for all chains |
| tms | output | 32 | Mode-select line for each chain |
| tdi | output | 32 | Data-in line for each chain |
| tdo | input | 32 | Data-out line from each chain |

## Verification
If the sequencer state is wrong, TCK and busy lose their fixed shape: one low setup cycle followed by exactly the programmed number of high cycles. The bench counts both phases at every system clock, so a wrong state shows within one TCK period. If the write gating is wrong, a write made during busy reaches `tdi` or the read-back path. This is visible the cycle after the write. A capture on the wrong edge shows up on the next read of address 6, because the bench flips `tdo` as soon as TCK is seen high.

// File: rtl/mcj_pkg.sv
package mcj_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HIGH  = 2'd2
    } seq_state_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_TDI  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TMS  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] A_HOLD = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
    localparam logic [ADDR_W-1:0] A_TDO  = 3'd6;

endpackage

// File: rtl/mcj_regfile.sv
module mcj_regfile
    import mcj_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NCH-1:0]    wdata,
    input  logic              busy,
    output logic [NCH-1:0]    tdi_q,
    output logic [NCH-1:0]    tms_q,
    output logic [NCH-1:0]    mask_q,
    output logic [HOLD_W-1:0] hold_q,
    output logic              go
);

    logic wr_ok;

    // Writes are accepted only while the sequencer is idle (R8)
    assign wr_ok = wr && !busy;
    assign go    = wr_ok && (addr == A_CMD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdi_q  <= '0;
            tms_q  <= '0;
            mask_q <= '1;
            hold_q <= HOLD_W'(1);
        end else if (wr_ok) begin
            unique case (addr)
                A_TDI:   tdi_q  <= wdata;
                A_TMS:   tms_q  <= wdata;
                A_MASK:  mask_q <= wdata;
                A_HOLD:  hold_q <= wdata[HOLD_W-1:0];
                default: ;
            endcase
        end
    end

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(tdi_q) && $stable(tms_q) && $stable(mask_q) && $stable(hold_q)));

endmodule

// File: rtl/mcj_seq.sv
module mcj_seq
    import mcj_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [HOLD_W-1:0] hold,
    output logic              tck,
    output logic              busy,
    output logic              sample_en
);

    seq_state_t        state_q, state_d;
    logic [HOLD_W-1:0] cnt_q, cnt_d;
    logic [HOLD_W-1:0] hold_eff;

    assign hold_eff = (hold == '0) ? HOLD_W'(1) : hold;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_SETUP;             // go
            end
            ST_SETUP: begin
                state_d = ST_HIGH;                      // rise
                cnt_d   = hold_eff - HOLD_W'(1);
            end
            ST_HIGH: begin
                if (cnt_q == '0) state_d = ST_IDLE;     // fall
                else             cnt_d   = cnt_q - HOLD_W'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        tck       = 1'b0;
        busy      = 1'b0;
        sample_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SETUP: begin busy = 1'b1; sample_en = 1'b1; end
            ST_HIGH:  begin busy = 1'b1; tck = 1'b1; end
            default:  ;
        endcase
    end

    // run length of the current TCK high phase, for the checks below
    logic [HOLD_W:0] hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_run <= '0;
        else if (tck) hi_run <= hi_run + 1'b1;
        else          hi_run <= '0;
    end

    p_tck_low_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    p_setup_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tck);

    p_high_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> (hi_run < {1'b0, hold_eff}));

    p_high_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tck) |-> (hi_run == {1'b0, hold_eff}) && !busy);

endmodule

// File: rtl/mcj_lane.sv
module mcj_lane (
    input  logic tdi_bit,
    input  logic tms_bit,
    input  logic enable,
    output logic tdi_o,
    output logic tms_o
);

    // a disabled chain is parked: TMS high keeps its controller in reset, TDI low
    always_comb begin
        if (enable) begin
            tdi_o = tdi_bit;
            tms_o = tms_bit;
        end else begin
            tdi_o = 1'b0;
            tms_o = 1'b1;
        end
    end

endmodule

// File: rtl/mcj_driver.sv
module mcj_driver
    import mcj_pkg::*;
#(
    parameter  int NMEZZ  = 4,
    parameter  int CPM    = 8,
    parameter  int HOLD_W = 8,
    localparam int NCH    = NMEZZ * CPM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [NCH-1:0]    host_wdata,
    output logic [NCH-1:0]    host_rdata,
    output logic              tck,
    output logic [NCH-1:0]    tms,
    output logic [NCH-1:0]    tdi,
    input  logic [NCH-1:0]    tdo
);

    logic [NCH-1:0]    tdi_q, tms_q, mask_q, cap_q;
    logic [HOLD_W-1:0] hold_q;
    logic              go, busy, sample_en;

    mcj_regfile #(.NCH(NCH), .HOLD_W(HOLD_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (host_wr),
        .addr   (host_addr),
        .wdata  (host_wdata),
        .busy   (busy),
        .tdi_q  (tdi_q),
        .tms_q  (tms_q),
        .mask_q (mask_q),
        .hold_q (hold_q),
        .go     (go)
    );

    mcj_seq #(.HOLD_W(HOLD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .hold      (hold_q),
        .tck       (tck),
        .busy      (busy),
        .sample_en (sample_en)
    );

    // one lane per chain; word bit CPM*m+k serves chain k of mezzanine m
    for (genvar m = 0; m < NMEZZ; m++) begin : g_mezz
        for (genvar k = 0; k < CPM; k++) begin : g_chain
            localparam int B = m * CPM + k;
            mcj_lane u_lane (
                .tdi_bit (tdi_q[B]),
                .tms_bit (tms_q[B]),
                .enable  (mask_q[B]),
                .tdi_o   (tdi[B]),
                .tms_o   (tms[B])
            );
        end
    end

    // TDO of every chain captured on the edge that raises TCK
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cap_q <= '0;
        else if (sample_en) cap_q <= tdo;
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_TDI:   host_rdata = tdi_q;
            A_TMS:   host_rdata = tms_q;
            A_MASK:  host_rdata = mask_q;
            A_HOLD:  host_rdata = NCH'(hold_q);
            A_STAT:  host_rdata = NCH'(busy);
            A_TDO:   host_rdata = cap_q;
            default: host_rdata = '0;
        endcase
    end

    p_capture_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_q) |-> $rose(tck));

    p_lines_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(tdi) && $stable(tms)));

endmodule

// File: tb/sim_mcj_driver.sv
module sim_mcj_driver;

    localparam int NCH = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_wr = 1'b0;
    logic [2:0]      host_addr = 3'd5;
    logic [NCH-1:0]  host_wdata = '0;
    logic [NCH-1:0]  host_rdata;
    logic            tck;
    logic [NCH-1:0]  tms, tdi;
    logic [NCH-1:0]  tdo = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mcj_driver u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .tck(tck),
        .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NCH-1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 3'd5;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NCH-1:0] v);
        host_addr = a;
        #1 v = host_rdata;
        host_addr = 3'd5;
        #1;
    endtask

    // Issue a command; count setup and high cycles; flip tdo once TCK is high.
    task automatic run_cycle(input logic [NCH-1:0] pat, output int setup, output int high);
        int guard;
        tdo = pat;
        setup = 0; high = 0; guard = 0;
        wr(3'd4, '0);
        while (guard < 600) begin
            host_addr = 3'd5;
            #1;
            if (host_rdata[0] == 1'b0) break;
            if (tck) begin high++; tdo = ~pat; end
            else setup++;
            @(negedge clk);
            guard++;
        end
        #1;
        check("R5 tck low after busy", {31'd0, tck}, '0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] v;
        int s, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check("R9 tck", {31'd0, tck}, '0);
        check("R9 tdi", tdi, '0);
        check("R9 tms", tms, '0);
        rd(3'd5, v); check("R9 busy", v, '0);
        rd(3'd2, v); check("R9 mask", v, '1);
        rd(3'd3, v); check("R9 hold", v, 32'd1);
        rd(3'd6, v); check("R9 capture", v, '0);

        // R1 walking one on TDI, each mezzanine/chain position
        for (int b = 0; b < NCH; b++) begin
            wr(3'd0, 32'd1 << b);
            #1;
            check($sformatf("R1 tdi mezz %0d chain %0d", b / 8, b % 8), tdi, 32'd1 << b);
            rd(3'd0, v); check("R1 readback", v, 32'd1 << b);
        end
        // R2 walking zero on TMS
        for (int b = 0; b < NCH; b++) begin
            wr(3'd1, ~(32'd1 << b));
            #1;
            check($sformatf("R2 tms mezz %0d chain %0d", b / 8, b % 8), tms, ~(32'd1 << b));
            rd(3'd1, v); check("R2 readback", v, ~(32'd1 << b));
        end

        // R3 mask sweep with TDI all ones and TMS all zeros
        wr(3'd0, '1);
        wr(3'd1, '0);
        for (int b = 0; b <= NCH; b++) begin
            logic [NCH-1:0] m;
            m = (b == NCH) ? 32'h00FF_0F0F : ~(32'd1 << b);
            wr(3'd2, m);
            #1;
            check("R3 tdi masked", tdi, m);
            check("R3 tms masked", tms, ~m);
            rd(3'd2, v); check("R3 mask readback", v, m);
        end
        wr(3'd2, '1);

        // R4 R5 R6 sweep over high time
        for (int hv = 0; hv <= 9; hv++) begin
            logic [NCH-1:0] pat;
            int hh;
            hh = (hv == 9) ? 255 : hv;
            pat = 32'h1234_5678 * (hv + 3) ^ 32'hA5A5_0000;
            wr(3'd3, 32'(hh));
            rd(3'd3, v); check("R4 hold readback", v, 32'(hh));
            run_cycle(pat, s, h);
            check($sformatf("R5 setup cycles hold %0d", hh), 32'(s), 32'd1);
            check($sformatf("R4 high cycles hold %0d", hh), 32'(h), (hh == 0) ? 32'd1 : 32'(hh));
            rd(3'd6, v); check("R6 captured tdo", v, pat);
            rd(3'd5, v); check("R7 status idle", v, '0);
        end

        // R7 R8 R10 writes during busy
        wr(3'd0, 32'hCAFE_F00D);
        wr(3'd1, 32'h0F0F_3C3C);
        wr(3'd3, 32'd4);
        wr(3'd4, '0);
        rd(3'd5, v); check("R7 busy set", v, 32'd1);
        wr(3'd0, 32'h1111_2222);
        #1; check("R10 tdi during busy", tdi, 32'hCAFE_F00D);
        wr(3'd2, '0);
        #1; check("R10 tms during busy", tms, 32'h0F0F_3C3C);
        wr(3'd4, '0);
        for (int i = 0; i < 20; i++) @(negedge clk);
        #1;
        check("R8 tdi kept", tdi, 32'hCAFE_F00D);
        check("R8 tms kept", tms, 32'h0F0F_3C3C);
        rd(3'd2, v); check("R8 mask kept", v, '1);
        rd(3'd3, v); check("R8 hold kept", v, 32'd4);
        rd(3'd5, v); check("R8 no extra period", v, '0);
        // R8 hold write during busy ignored: period length stays 4
        wr(3'd4, '0);
        wr(3'd3, 32'd9);
        for (int i = 0; i < 10; i++) @(negedge clk);
        rd(3'd3, v); check("R8 hold write dropped", v, 32'd4);
        run_cycle(32'h0BAD_BEEF, s, h);
        check("R4 high after dropped write", 32'(h), 32'd4);
        rd(3'd6, v); check("R6 capture second", v, 32'h0BAD_BEEF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule